// File: doc/BRIEF.md
# Collection-Banked Pin Function Multiplexer

This block controls a bank of general-purpose pins arranged in collections of eight. Software reaches it through a byte-wide register bus. Each collection has its own eight-byte window. For every pin, the window holds a 2-bit function code, an output-enable bit and an output-data bit, and it also holds a read-only byte of synchronized pad levels.

With function code 0, a pin is under software control. Its pad output enable and pad output level then come from the collection's drive and data bytes. Codes 1, 2 and 3 give the pin to internal client A, B or C. The chosen client then supplies the pin's output enable and output level, and the software drive and data bits are masked. Pad levels are always sampled through a two-flop synchronizer, whatever function a pin has. Software can preload a pin's data bit while the pin is still an input, and then set the drive bit, so the pad never drives a stale level.

Top module: `gp_pinmux`

## Requirements
- R1: After reset, every function code, drive bit and data bit is 0. Both `pad_oe_o` and `pad_out_o` are all zeros.
- R2: Collection c (0 to NUM_COLL-1) has a window at byte address BASE_ADDR + 8*c. Within the window: offset 0 holds the codes of pins 0-3, offset 1 the codes of pins 4-7, offset 2 the drive byte, offset 3 the data byte, and offset 6 the input byte. A read with `bus_re_i` high presents its data on `bus_rdata_o` after the next rising clock edge. Pin number is c*8 + index, and index is also the bit position in the drive, data and input bytes.
- R3: The function code of pin index i sits in bits [2*(i mod 4)+1 : 2*(i mod 4)] of offset 0 when i < 4, and of offset 1 otherwise.
- R4: A read of offsets 0, 1, 2 or 3 returns the value last written there.
- R5: Writes to offsets 4, 5, 6 and 7 change no state. Reads of offsets 4, 5 and 7 return 0. An address outside every window reads 0, and writing it changes no state.
- R6: Function code 0 (GPIO) drives a pin's pad output enable from its drive bit (1 = output) and its pad output level from its data bit.
- R7: Function codes 1, 2 and 3 take the pin's output enable and output level from client A, B and C in that order. In those modes the drive and data bits have no effect on the pad.
- R8: The input byte shows pad levels through two synchronizing flops, for any function code. After a pad level changes, a read issued one or two edges later still returns the old level. A read issued three edges later returns the new level.
- R9: `pad_out_o` follows the data bit of a GPIO pin even while that pin's drive bit is 0. The level is therefore already in place when the drive bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 8 | Read data, registered |
| pad_in_i | input | NUM_COLL*8 | Pad input levels, asynchronous |
| pad_oe_o | output | NUM_COLL*8 | Pad output enable |
| pad_out_o | output | NUM_COLL*8 | Pad output level |
| cla_oe_i | input | NUM_COLL*8 | Client A output enable per pin |
| cla_out_i | input | NUM_COLL*8 | Client A output level per pin |
| clb_oe_i | input | NUM_COLL*8 | Client B output enable per pin |
| clb_out_i | input | NUM_COLL*8 | Client B output level per pin |
| clc_oe_i | input | NUM_COLL*8 | Client C output enable per pin |
| clc_out_i | input | NUM_COLL*8 | Client C output level per pin |

## Verification
A corrupted function code or drive bit shows up on `pad_oe_o` and `pad_out_o` in the cycle right after the write that produced it. The pad mux is combinational from the registers, so the bench compares the whole pad vectors against an arithmetic model after every configuration change, with clients driving distinct patterns. A wrong decode of a window, offset or field position appears either on those vectors or on the registered read one edge later. A synchronizer with the wrong depth changes which read first sees a new pad level, and the bench samples that on three consecutive reads.

// File: rtl/gp_pinmux_pkg.sv
package gp_pinmux_pkg;
  localparam int unsigned COLL_PINS   = 8;
  localparam int unsigned NUM_CLIENTS = 3;

  localparam logic [2:0] OFF_SEL_LO = 3'd0;
  localparam logic [2:0] OFF_SEL_HI = 3'd1;
  localparam logic [2:0] OFF_DRIVE  = 3'd2;
  localparam logic [2:0] OFF_DATA   = 3'd3;
  localparam logic [2:0] OFF_SENSE  = 3'd6;

  typedef enum logic [1:0] {
    FN_GPIO = 2'd0,
    FN_CL_A = 2'd1,
    FN_CL_B = 2'd2,
    FN_CL_C = 2'd3
  } fn_e;

  typedef logic [COLL_PINS-1:0] pin_vec_t;
endpackage

// File: rtl/gp_pinmux_sync.sv
module gp_pinmux_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign q_o = sync_q;

  // R8: output is the input two edges earlier
  a_r8_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gp_pinmux_pin.sv
module gp_pinmux_pin
  import gp_pinmux_pkg::*;
(
  input  fn_e                    sel_i,
  input  logic                   gpio_oe_i,
  input  logic                   gpio_do_i,
  input  logic [NUM_CLIENTS-1:0] cl_oe_i,
  input  logic [NUM_CLIENTS-1:0] cl_do_i,
  output logic                   pad_oe_o,
  output logic                   pad_do_o
);
  always_comb begin
    unique case (sel_i)
      FN_CL_A: begin pad_oe_o = cl_oe_i[0]; pad_do_o = cl_do_i[0]; end
      FN_CL_B: begin pad_oe_o = cl_oe_i[1]; pad_do_o = cl_do_i[1]; end
      FN_CL_C: begin pad_oe_o = cl_oe_i[2]; pad_do_o = cl_do_i[2]; end
      default: begin pad_oe_o = gpio_oe_i;  pad_do_o = gpio_do_i;  end
    endcase
  end
endmodule

// File: rtl/gp_pinmux_coll.sv
module gp_pinmux_coll
  import gp_pinmux_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_i,
  input  logic [2:0]                          off_i,
  input  logic [7:0]                          wdata_i,
  input  pin_vec_t                            sense_i,
  input  logic [NUM_CLIENTS-1:0][COLL_PINS-1:0] cl_oe_i,
  input  logic [NUM_CLIENTS-1:0][COLL_PINS-1:0] cl_do_i,
  output logic [7:0]                          rdata_o,
  output pin_vec_t                            pad_oe_o,
  output pin_vec_t                            pad_do_o
);
  localparam int unsigned HALF = COLL_PINS / 2;

  fn_e      sel_q [COLL_PINS];
  pin_vec_t drv_q, dat_q;
  logic [2*COLL_PINS-1:0] sel_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < COLL_PINS; i++) sel_q[i] <= FN_GPIO;
      drv_q <= '0;
      dat_q <= '0;
    end else if (wr_i) begin
      case (off_i)
        OFF_SEL_LO: for (int i = 0; i < HALF; i++) sel_q[i]      <= fn_e'(wdata_i[2*i +: 2]);
        OFF_SEL_HI: for (int i = 0; i < HALF; i++) sel_q[HALF+i] <= fn_e'(wdata_i[2*i +: 2]);
        OFF_DRIVE:  drv_q <= wdata_i;
        OFF_DATA:   dat_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_SEL_LO: for (int i = 0; i < HALF; i++) rdata_o[2*i +: 2] = sel_q[i];
      OFF_SEL_HI: for (int i = 0; i < HALF; i++) rdata_o[2*i +: 2] = sel_q[HALF+i];
      OFF_DRIVE:  rdata_o = drv_q;
      OFF_DATA:   rdata_o = dat_q;
      OFF_SENSE:  rdata_o = sense_i;
      default:    rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < COLL_PINS; g++) begin : g_pin
    assign sel_flat[2*g +: 2] = sel_q[g];
    gp_pinmux_pin u_pin (
      .sel_i     (sel_q[g]),
      .gpio_oe_i (drv_q[g]),
      .gpio_do_i (dat_q[g]),
      .cl_oe_i   ({cl_oe_i[2][g], cl_oe_i[1][g], cl_oe_i[0][g]}),
      .cl_do_i   ({cl_do_i[2][g], cl_do_i[1][g], cl_do_i[0][g]}),
      .pad_oe_o  (pad_oe_o[g]),
      .pad_do_o  (pad_do_o[g])
    );
  end

  // R6: a drive write on an all-GPIO collection reaches the pads next cycle
  a_r6_drive_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_DRIVE && sel_flat == '0) |=> (pad_oe_o == $past(wdata_i)));

  // R4: data byte reads back what was written
  a_r4_data_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i == OFF_DATA) |=> ((off_i != OFF_DATA) || (rdata_o == $past(wdata_i))));

  // R5: offsets 4..7 hold no writable state
  a_r5_dead_offsets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && off_i[2]) |=> ($stable(sel_flat) && $stable(drv_q) && $stable(dat_q)));
endmodule

// File: rtl/gp_pinmux.sv
module gp_pinmux
  import gp_pinmux_pkg::*;
#(
  parameter int unsigned          NUM_COLL  = 18,
  parameter int unsigned          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]    BASE_ADDR = 'h20
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ADDR_W-1:0]               bus_addr_i,
  input  logic                            bus_we_i,
  input  logic [7:0]                      bus_wdata_i,
  input  logic                            bus_re_i,
  output logic [7:0]                      bus_rdata_o,
  input  logic [NUM_COLL*COLL_PINS-1:0]   pad_in_i,
  output logic [NUM_COLL*COLL_PINS-1:0]   pad_oe_o,
  output logic [NUM_COLL*COLL_PINS-1:0]   pad_out_o,
  input  logic [NUM_COLL*COLL_PINS-1:0]   cla_oe_i,
  input  logic [NUM_COLL*COLL_PINS-1:0]   cla_out_i,
  input  logic [NUM_COLL*COLL_PINS-1:0]   clb_oe_i,
  input  logic [NUM_COLL*COLL_PINS-1:0]   clb_out_i,
  input  logic [NUM_COLL*COLL_PINS-1:0]   clc_oe_i,
  input  logic [NUM_COLL*COLL_PINS-1:0]   clc_out_i
);
  localparam int unsigned NPINS = NUM_COLL * COLL_PINS;
  localparam int unsigned IDX_W = ADDR_W - 3;

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  cidx;
  logic [2:0]        off;
  logic              hit;
  logic [NPINS-1:0]  sense;
  logic [NUM_COLL-1:0] coll_wr;
  logic [7:0]        coll_rdata [NUM_COLL];
  logic [7:0]        rd_mux;
  logic [7:0]        rdata_q;

  assign rel  = bus_addr_i - BASE_ADDR;
  assign cidx = rel[ADDR_W-1:3];
  assign off  = rel[2:0];
  assign hit  = (bus_addr_i >= BASE_ADDR) && (cidx < IDX_W'(NUM_COLL));

  gp_pinmux_sync #(.WIDTH(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sense)
  );

  for (genvar c = 0; c < NUM_COLL; c++) begin : g_coll
    logic [NUM_CLIENTS-1:0][COLL_PINS-1:0] cl_oe, cl_do;
    assign cl_oe = {clc_oe_i[c*COLL_PINS +: COLL_PINS],
                    clb_oe_i[c*COLL_PINS +: COLL_PINS],
                    cla_oe_i[c*COLL_PINS +: COLL_PINS]};
    assign cl_do = {clc_out_i[c*COLL_PINS +: COLL_PINS],
                    clb_out_i[c*COLL_PINS +: COLL_PINS],
                    cla_out_i[c*COLL_PINS +: COLL_PINS]};
    assign coll_wr[c] = bus_we_i && hit && (cidx == IDX_W'(c));

    gp_pinmux_coll u_coll (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (coll_wr[c]),
      .off_i    (off),
      .wdata_i  (bus_wdata_i),
      .sense_i  (sense[c*COLL_PINS +: COLL_PINS]),
      .cl_oe_i  (cl_oe),
      .cl_do_i  (cl_do),
      .rdata_o  (coll_rdata[c]),
      .pad_oe_o (pad_oe_o[c*COLL_PINS +: COLL_PINS]),
      .pad_do_o (pad_out_o[c*COLL_PINS +: COLL_PINS])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_COLL; c++)
      if (cidx == IDX_W'(c)) rd_mux = coll_rdata[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_re_i) rdata_q <= hit ? rd_mux : 8'h00;
  end

  assign bus_rdata_o = rdata_q;

  // R5: a read outside every window returns zero
  a_r5_miss_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_re_i && !hit) |=> (bus_rdata_o == 8'h00));

  // R2: read data only changes on a read strobe
  a_r2_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/test_gp_pinmux.sv
module test_gp_pinmux;
  localparam int NC = 18;
  localparam int NP = NC * 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pad_in = '0, pad_oe, pad_out;
  logic [NP-1:0] cla_oe = '0, cla_out = '0, clb_oe = '0, clb_out = '0, clc_oe = '0, clc_out = '0;

  int n_chk = 0, n_fail = 0;

  logic [1:0]    m_sel [NP];
  logic [NP-1:0] m_drv = '0, m_dat = '0;

  always #4ns clk = ~clk;

  gp_pinmux i_gp_pinmux (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(bus_addr), .bus_we_i(bus_we),
    .bus_wdata_i(bus_wdata), .bus_re_i(bus_re), .bus_rdata_o(bus_rdata),
    .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out),
    .cla_oe_i(cla_oe), .cla_out_i(cla_out), .clb_oe_i(clb_oe), .clb_out_i(clb_out),
    .clc_oe_i(clc_oe), .clc_out_i(clc_out)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkv(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] waddr(input int c, input int off);
    return 8'(32 + 8 * c + off);
  endfunction

  task automatic wr(input int c, input int off, input logic [7:0] d);
    bus_write(waddr(c, off), d);
    case (off)
      0: for (int i = 0; i < 4; i++) m_sel[c*8 + i]     = d[2*i +: 2];
      1: for (int i = 0; i < 4; i++) m_sel[c*8 + 4 + i] = d[2*i +: 2];
      2: m_drv[c*8 +: 8] = d;
      3: m_dat[c*8 +: 8] = d;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] m_byte(input int c, input int off);
    logic [7:0] r = '0;
    case (off)
      0: for (int i = 0; i < 4; i++) r[2*i +: 2] = m_sel[c*8 + i];
      1: for (int i = 0; i < 4; i++) r[2*i +: 2] = m_sel[c*8 + 4 + i];
      2: r = m_drv[c*8 +: 8];
      3: r = m_dat[c*8 +: 8];
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic set_clients(input int seed);
    for (int p = 0; p < NP; p++) begin
      cla_oe[p]  = ((p * 5 + seed) % 3) == 0;
      cla_out[p] = ((p * 3 + seed) % 4) < 2;
      clb_oe[p]  = ((p * 7 + seed) % 5) < 2;
      clb_out[p] = ((p + seed) % 3) != 1;
      clc_oe[p]  = ((p * 11 + seed) % 2) == 1;
      clc_out[p] = ((p * 13 + seed) % 7) < 3;
    end
  endtask

  task automatic check_pads(input string tag);
    logic [NP-1:0] eo, ed;
    for (int p = 0; p < NP; p++) begin
      case (m_sel[p])
        2'd0: begin eo[p] = m_drv[p];  ed[p] = m_dat[p];  end
        2'd1: begin eo[p] = cla_oe[p]; ed[p] = cla_out[p]; end
        2'd2: begin eo[p] = clb_oe[p]; ed[p] = clb_out[p]; end
        default: begin eo[p] = clc_oe[p]; ed[p] = clc_out[p]; end
      endcase
    end
    @(negedge clk);
    chkv({tag, " pad_oe"}, pad_oe, eo);
    chkv({tag, " pad_out"}, pad_out, ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r, r1, r2, r3;
    for (int p = 0; p < NP; p++) m_sel[p] = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: reset state
    @(negedge clk);
    chkv("R1 pad_oe reset", pad_oe, '0);
    chkv("R1 pad_out reset", pad_out, '0);
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 4; o++) begin
        bus_read(waddr(c, o), r);
        chk8("R1 register reset", r, 8'h00);
      end

    // R2 R3 R4: distinct per-window patterns, readback, pad decode
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 4; o++)
        wr(c, o, 8'((c * 37 + o * 11) ^ 8'h5A));
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 4; o++) begin
        bus_read(waddr(c, o), r);
        chk8("R4 readback", r, m_byte(c, o));
      end
    set_clients(1);
    check_pads("R3 R6 R7 mixed seed1");
    set_clients(4);
    check_pads("R3 R6 R7 mixed seed4");

    // R7 R6: every code on every pin; GPIO bits toggled under client modes
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < NC; c++) begin
        wr(c, 0, 8'(s * 8'h55));
        wr(c, 1, 8'(s * 8'h55));
      end
      set_clients(s + 2);
      check_pads("R7 uniform code");
      for (int c = 0; c < NC; c++) begin
        wr(c, 2, ~m_drv[c*8 +: 8]);
        wr(c, 3, 8'(c * 29 + s));
      end
      check_pads("R7 gpio bits masked");
    end

    // R3: single pin per position set to client C in collection 9
    for (int i = 0; i < 8; i++) begin
      wr(9, 0, (i < 4) ? 8'(2'b11 << (2 * i)) : 8'h00);
      wr(9, 1, (i >= 4) ? 8'(2'b11 << (2 * (i - 4))) : 8'h00);
      check_pads("R3 field position");
    end

    // R9: data preloaded while input, then drive enabled
    wr(4, 0, 8'h00); wr(4, 1, 8'h00); wr(4, 2, 8'h00); wr(4, 3, 8'hA5);
    @(negedge clk);
    chk8("R9 preload out", pad_out[39:32], 8'hA5);
    chk8("R9 preload oe", pad_oe[39:32], 8'h00);
    wr(4, 2, 8'hFF);
    @(negedge clk);
    chk8("R9 drive out", pad_out[39:32], 8'hA5);
    chk8("R9 drive oe", pad_oe[39:32], 8'hFF);

    // R5: dead offsets and out-of-window addresses
    for (int o = 4; o < 8; o++) wr(2, o, 8'hFF);
    for (int o = 0; o < 4; o++) begin
      bus_read(waddr(2, o), r);
      chk8("R5 dead write kept", r, m_byte(2, o));
    end
    bus_read(waddr(2, 4), r); chk8("R5 read off4", r, 8'h00);
    bus_read(waddr(2, 5), r); chk8("R5 read off5", r, 8'h00);
    bus_read(waddr(2, 7), r); chk8("R5 read off7", r, 8'h00);
    bus_write(8'h10, 8'hFF); bus_write(8'h1F, 8'hFF);
    bus_write(8'hB0, 8'hFF); bus_write(8'hFF, 8'hFF);
    bus_read(8'h10, r); chk8("R5 miss read low", r, 8'h00);
    bus_read(8'hB0, r); chk8("R5 miss read high", r, 8'h00);
    bus_read(8'hFF, r); chk8("R5 miss read top", r, 8'h00);
    for (int c = 0; c < NC; c++)
      for (int o = 0; o < 4; o++) begin
        bus_read(waddr(c, o), r);
        chk8("R5 miss write kept", r, m_byte(c, o));
      end
    check_pads("R5 pads kept");

    // R8: synchronizer latency on collection 7
    @(negedge clk);
    pad_in[56 +: 8] = 8'h3C;
    bus_addr = waddr(7, 6); bus_re = 1'b1;
    @(negedge clk); r1 = bus_rdata;
    @(negedge clk); r2 = bus_rdata;
    @(negedge clk); r3 = bus_rdata;
    bus_re = 1'b0;
    chk8("R8 latency edge1", r1, 8'h00);
    chk8("R8 latency edge2", r2, 8'h00);
    chk8("R8 latency edge3", r3, 8'h3C);

    // R8: pad sweep, independent of function codes
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) pad_in[p] = ((p * (k + 3) + k) % 5) < 2;
      repeat (3) @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        bus_read(waddr(c, 6), r);
        chk8("R8 input byte", r, pad_in[c*8 +: 8]);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule